// File: doc/BRIEF.md
# Debug Command Execution Engine

This block turns single debug commands into sequences on a target debug port. A host raises one of six command strobes (read a byte, write a byte, power the target on, power it off, wait, echo) together with an 8-bit argument. The engine runs the matching low-level operation and reports any result on an 8-bit output with a one-cycle valid flag.

The byte shifter and the power switch sit outside the block. Each is reached through a level request that stays high until the peripheral returns a one-cycle done pulse. The engine accepts one command at a time. `ready` is high only when it is idle.

The result output has no back-pressure: `valid` is high for one cycle, and the consumer must take `data_out` in that cycle. `data_out` keeps its value until the next result. On the command side, `ready` is the only handshake. A strobe that arrives while `ready` is low is dropped, and is neither queued nor remembered.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset `ready`=1, `valid`=0, `data_out`=0, `xfer_req`=0, `pwr_req`=0 and `line_hold_low`=0.
- R2: A command is accepted only at a clock edge where `ready` is high and exactly one strobe is high. A strobe while `ready` is low, or two or more strobes together, is ignored: no request starts and `ready` stays as it was.
- R3: `ready` is low from the cycle after acceptance. It goes high again in the cycle after the operation finishes: after the done pulse for write/power, after the valid cycle for read/echo, and after the last wait cycle for delay.
- R4: Read raises `xfer_req` with `xfer_dir`=0 from the cycle after acceptance until `xfer_done` is sampled. In the next cycle `valid`=1 and `data_out` equals `xfer_rdata` as sampled with `xfer_done`.
- R5: Write raises `xfer_req` with `xfer_dir`=1 and `xfer_wdata` equal to `data_in` captured at acceptance, until `xfer_done` is sampled.
- R6: Echo gives `valid`=1 and `data_out` equal to the captured `data_in` in the cycle after acceptance.
- R7: `valid` never stays high for two consecutive cycles, and `data_out` changes only in a cycle where `valid` is high.
- R8: Power-on raises `pwr_req` with `pwr_on`=1 and `line_hold_low`=1 until `pwr_done` is sampled. Power-off raises `pwr_req` with `pwr_on`=0 and `line_hold_low`=0.
- R9: A delay with argument N>0 keeps `ready` low for exactly 16·N cycles. With N=0 it keeps `ready` low for exactly one cycle.
- R10: Write, power-on, power-off and delay produce no `valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_read | input | 1 | Strobe: read one byte from target |
| cmd_write | input | 1 | Strobe: write `data_in` to target |
| cmd_pwr_on | input | 1 | Strobe: power target on |
| cmd_pwr_off | input | 1 | Strobe: power target off |
| cmd_wait | input | 1 | Strobe: wait 16·`data_in` cycles |
| cmd_echo | input | 1 | Strobe: return `data_in` |
| data_in | input | 8 | Command argument |
| ready | output | 1 | Engine idle, strobe may be given |
| valid | output | 1 | One-cycle result flag |
| data_out | output | 8 | Last result byte |
| xfer_req | output | 1 | Byte transfer request (level) |
| xfer_dir | output | 1 | 1 = write, 0 = read |
| xfer_wdata | output | 8 | Byte to send |
| xfer_rdata | input | 8 | Byte received, valid with `xfer_done` |
| xfer_done | input | 1 | Transfer finished pulse |
| pwr_req | output | 1 | Power change request (level) |
| pwr_on | output | 1 | Requested power level |
| pwr_done | input | 1 | Power change finished pulse |
| line_hold_low | output | 1 | Drive debug line low during power-up |

## Verification
If the sequencer is in the wrong state, `ready` or one of the request lines is wrong in the very next cycle, because all of them come straight from state registers. A wrong delay count shows at the end of the wait, when `ready` rises too early or too late by the count error. A wrong result capture shows as a wrong `data_out` in the single cycle where `valid` is high, and that value persists afterwards. Comparing every cycle against a behavioural model therefore pins most faults to the cycle where they first appear.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int NUM_CMDS = 6;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_PWR_ON  = 3'd3,
    OP_PWR_OFF = 3'd4,
    OP_WAIT    = 3'd5,
    OP_ECHO    = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_XFER = 3'd1,
    ST_PWR  = 3'd2,
    ST_WAIT = 3'd3,
    ST_RESP = 3'd4
  } state_e;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_cmd_pkg::*;
(
  input  logic [NUM_CMDS-1:0] strobes,
  output op_e                 op
);
  localparam int CNT_W = $clog2(NUM_CMDS + 1);

  logic [CNT_W-1:0] hot_cnt;

  always_comb begin
    hot_cnt = '0;
    for (int i = 0; i < NUM_CMDS; i++) begin
      hot_cnt = hot_cnt + CNT_W'(strobes[i]);
    end
  end

  // strobe bit i maps to opcode i+1; anything but exactly one hot is no-op
  always_comb begin
    op = OP_NONE;
    if (hot_cnt == CNT_W'(1)) begin
      for (int i = 0; i < NUM_CMDS; i++) begin
        if (strobes[i]) op = op_e'(3'(i + 1));
      end
    end
  end
endmodule

// File: rtl/dbg_delay_timer.sv
module dbg_delay_timer #(
  parameter int DW          = 8,
  parameter int DELAY_SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] amount,
  input  logic          tick,
  output logic          expired
);
  localparam int CW = DW + DELAY_SHIFT;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  // N>0 waits N<<SHIFT cycles; N=0 still spends one cycle in the wait state
  assign load_val = (amount == '0) ? '0
                  : ({amount, {DELAY_SHIFT{1'b0}}} - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (tick && cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign expired = (cnt_q == '0);

  p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/dbg_result_reg.sv
module dbg_result_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
  import dbg_cmd_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DELAY_SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_read,
  input  logic          cmd_write,
  input  logic          cmd_pwr_on,
  input  logic          cmd_pwr_off,
  input  logic          cmd_wait,
  input  logic          cmd_echo,
  input  logic [DW-1:0] data_in,
  output logic          ready,
  output logic          valid,
  output logic [DW-1:0] data_out,
  output logic          xfer_req,
  output logic          xfer_dir,
  output logic [DW-1:0] xfer_wdata,
  input  logic [DW-1:0] xfer_rdata,
  input  logic          xfer_done,
  output logic          pwr_req,
  output logic          pwr_on,
  input  logic          pwr_done,
  output logic          line_hold_low
);
  logic [NUM_CMDS-1:0] strobes;
  op_e                 op;
  state_e              state_q, state_d;
  logic                accept;
  logic                tmr_expired;
  logic                res_load;
  logic [DW-1:0]       res_d;
  logic                dir_q, pwr_on_q;
  logic [DW-1:0]       wdata_q;

  assign strobes = {cmd_echo, cmd_wait, cmd_pwr_off, cmd_pwr_on, cmd_write, cmd_read};

  dbg_cmd_decode u_decode (
    .strobes (strobes),
    .op      (op)
  );

  assign ready  = (state_q == ST_IDLE);
  assign accept = ready && (op != OP_NONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        unique case (op)
          OP_READ, OP_WRITE:    state_d = ST_XFER;
          OP_PWR_ON, OP_PWR_OFF: state_d = ST_PWR;
          OP_WAIT:              state_d = ST_WAIT;
          OP_ECHO:              state_d = ST_RESP;
          default:              state_d = ST_IDLE;
        endcase
      end
      ST_XFER: if (xfer_done) state_d = dir_q ? ST_IDLE : ST_RESP;
      ST_PWR:  if (pwr_done)  state_d = ST_IDLE;
      ST_WAIT: if (tmr_expired) state_d = ST_IDLE;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dir_q    <= 1'b0;
      wdata_q  <= '0;
      pwr_on_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept && (op == OP_READ || op == OP_WRITE)) begin
        dir_q   <= (op == OP_WRITE);
        wdata_q <= data_in;
      end
      if (accept && (op == OP_PWR_ON || op == OP_PWR_OFF)) begin
        pwr_on_q <= (op == OP_PWR_ON);
      end
    end
  end

  dbg_delay_timer #(.DW(DW), .DELAY_SHIFT(DELAY_SHIFT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept && op == OP_WAIT),
    .amount  (data_in),
    .tick    (state_q == ST_WAIT),
    .expired (tmr_expired)
  );

  // echo captures on acceptance; read captures when the transfer completes
  assign res_load = (accept && op == OP_ECHO) ||
                    (state_q == ST_XFER && xfer_done && !dir_q);
  assign res_d    = accept ? data_in : xfer_rdata;

  dbg_result_reg #(.DW(DW)) u_result (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (res_load),
    .d     (res_d),
    .q     (data_out)
  );

  assign valid         = (state_q == ST_RESP);
  assign xfer_req      = (state_q == ST_XFER);
  assign xfer_dir      = dir_q;
  assign xfer_wdata    = wdata_q;
  assign pwr_req       = (state_q == ST_PWR);
  assign pwr_on        = pwr_on_q;
  assign line_hold_low = pwr_req && pwr_on_q;

  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!xfer_req && !pwr_req));
  p_read_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_dir && xfer_done) |=> (valid && data_out == $past(xfer_rdata)));
  p_echo_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_ECHO) |=> (valid && data_out == $past(data_in)));
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(data_out));
  p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_hold_low |-> (pwr_req && pwr_on));
  p_no_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_WRITE || op == OP_PWR_ON || op == OP_PWR_OFF || op == OP_WAIT))
    |=> !valid);
endmodule

// File: tb/dbg_cmd_engine_bench.sv
module dbg_cmd_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_rd = 0, c_wr = 0, c_on = 0, c_off = 0, c_wait = 0, c_echo = 0;
  logic [7:0] din = 8'h00;
  logic ready, valid, xfer_req, xfer_dir, pwr_req, pwr_on, line_hold_low;
  logic [7:0] dout, xfer_wdata;
  logic [7:0] xfer_rdata = 8'h00;
  logic xfer_done = 1'b0, pwr_done = 1'b0;

  int tests = 0, fails = 0;
  int xfer_lat = 2, pwr_lat = 3;
  int vcount = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  dbg_cmd_engine u_dbg_cmd_engine (
    .clk(clk), .rst_n(rst_n),
    .cmd_read(c_rd), .cmd_write(c_wr), .cmd_pwr_on(c_on), .cmd_pwr_off(c_off),
    .cmd_wait(c_wait), .cmd_echo(c_echo), .data_in(din),
    .ready(ready), .valid(valid), .data_out(dout),
    .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_wdata(xfer_wdata),
    .xfer_rdata(xfer_rdata), .xfer_done(xfer_done),
    .pwr_req(pwr_req), .pwr_on(pwr_on), .pwr_done(pwr_done),
    .line_hold_low(line_hold_low)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: mode 0 idle,1 read,2 write,3 power,4 wait,5 result
  int m_mode = 0, m_left = 0;
  logic [7:0] m_dout = 0, m_wdata = 0;
  bit m_dir = 0, m_pon = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_dout = 0; m_wdata = 0; m_dir = 0; m_pon = 0; m_left = 0;
    end else begin
      case (m_mode)
        0: if ((c_rd + c_wr + c_on + c_off + c_wait + c_echo) == 1) begin
          if (c_rd)   begin m_mode = 1; m_dir = 0; m_wdata = din; end
          if (c_wr)   begin m_mode = 2; m_dir = 1; m_wdata = din; end
          if (c_on)   begin m_mode = 3; m_pon = 1; end
          if (c_off)  begin m_mode = 3; m_pon = 0; end
          if (c_wait) begin m_mode = 4; m_left = (din == 0) ? 1 : 16 * din; end
          if (c_echo) begin m_mode = 5; m_dout = din; end
        end
        1: if (xfer_done) begin m_dout = xfer_rdata; m_mode = 5; end
        2: if (xfer_done) m_mode = 0;
        3: if (pwr_done) m_mode = 0;
        4: begin m_left--; if (m_left == 0) m_mode = 0; end
        default: m_mode = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3", "ready", ready, m_mode == 0);
      check("R7", "valid", valid, m_mode == 5);
      check("R7", "data_out", dout, m_dout);
      check("R4", "xfer_req", xfer_req, (m_mode == 1 || m_mode == 2));
      check("R8", "pwr_req", pwr_req, m_mode == 3);
      check("R8", "line_hold_low", line_hold_low, (m_mode == 3) && m_pon);
      if (m_mode == 1 || m_mode == 2) check("R5", "xfer_dir", xfer_dir, m_dir);
      if (m_mode == 2) check("R5", "xfer_wdata", xfer_wdata, m_wdata);
      if (m_mode == 3) check("R8", "pwr_on", pwr_on, m_pon);
      if (valid) vcount++;
    end
  end

  // target models: byte shifter and power switch
  initial forever begin
    @(negedge clk);
    if (xfer_req) begin
      repeat (xfer_lat) @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (pwr_req) begin
      repeat (pwr_lat) @(negedge clk);
      pwr_done = 1'b1;
      @(negedge clk);
      pwr_done = 1'b0;
    end
  end

  task automatic strobe(input int which, input logic [7:0] d);
    while (!ready) @(negedge clk);
    din = d;
    c_rd = (which == 1); c_wr = (which == 2); c_on = (which == 3);
    c_off = (which == 4); c_wait = (which == 5); c_echo = (which == 6);
    @(negedge clk);
    {c_rd, c_wr, c_on, c_off, c_wait, c_echo} = '0;
  endtask

  task automatic idle_wait();
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic delay_len(input logic [7:0] n, input int exp, input string tag);
    int low = 0;
    strobe(5, n);
    while (!ready) begin low++; @(negedge clk); end
    check(tag, "delay ready-low cycles", low, exp);
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int v0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "ready", ready, 1);
    check("R1", "valid", valid, 0);
    check("R1", "data_out", dout, 0);
    check("R1", "requests", {xfer_req, pwr_req, line_hold_low}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 echo
    strobe(6, 8'hA5);
    check("R6", "echo valid", valid, 1);
    check("R6", "echo data", dout, 8'hA5);
    @(negedge clk);
    check("R7", "valid after one cycle", valid, 0);
    check("R3", "ready after echo", ready, 1);

    // R4 read
    xfer_rdata = 8'h3C; xfer_lat = 3;
    strobe(1, 8'h00);
    check("R3", "ready low after read accept", ready, 0);
    check("R4", "read dir", xfer_dir, 0);
    while (!valid) @(negedge clk);
    check("R4", "read data", dout, 8'h3C);
    idle_wait();

    // R5 / R10 write
    v0 = vcount;
    strobe(2, 8'h7E);
    check("R5", "write dir", xfer_dir, 1);
    check("R5", "write data", xfer_wdata, 8'h7E);
    idle_wait();
    check("R10", "no valid after write", vcount - v0, 0);
    check("R7", "data_out held", dout, 8'h3C);

    // R8 power on / off
    v0 = vcount;
    strobe(3, 8'h00);
    check("R8", "hold low during power-up", line_hold_low, 1);
    check("R8", "pwr_on level", pwr_on, 1);
    idle_wait();
    strobe(4, 8'h00);
    check("R8", "no hold on power-off", line_hold_low, 0);
    check("R8", "pwr_off level", pwr_on, 0);
    idle_wait();
    check("R10", "no valid after power", vcount - v0, 0);

    // R9 delays
    v0 = vcount;
    delay_len(8'd3, 48, "R9");
    delay_len(8'd0, 1, "R9");
    delay_len(8'd1, 16, "R9");
    check("R10", "no valid after delay", vcount - v0, 0);

    // R2 two strobes at once
    din = 8'h11; c_rd = 1; c_echo = 1;
    @(negedge clk);
    c_rd = 0; c_echo = 0;
    check("R2", "ready stays on double strobe", ready, 1);
    check("R2", "no transfer on double strobe", xfer_req, 0);
    check("R2", "no valid on double strobe", valid, 0);

    // R2 strobe while busy is dropped
    xfer_lat = 4; xfer_rdata = 8'hC3;
    strobe(1, 8'h00);
    din = 8'h99; c_echo = 1;
    @(negedge clk);
    c_echo = 0;
    while (!valid) @(negedge clk);
    check("R2", "read data unaffected by busy echo", dout, 8'hC3);
    @(negedge clk);
    check("R2", "busy echo dropped", valid, 0);
    check("R2", "ready after read", ready, 1);

    // zero-latency read and boundary echo values
    xfer_lat = 0; xfer_rdata = 8'hFF;
    strobe(1, 8'h00);
    while (!valid) @(negedge clk);
    check("R4", "fast read data", dout, 8'hFF);
    idle_wait();
    strobe(6, 8'h00);
    check("R6", "echo zero", dout, 8'h00);
    idle_wait();
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule